// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns the predicate fields of a predicated vector instruction into two 64-bit element masks, one for the source elements and one for the destination elements. A mask bit set to one means the element at that position takes part in the operation. The masks come from one of two places, chosen by the predicate mode. In integer mode a mask is a general register (r3, r10 or r30), its complement, a one-hot mask built from r3, or all ones. In condition mode the block reads one bit from each of a run of consecutive 4-bit condition fields, starting at a fixed field offset, and compares that bit with a required value.

The block receives the three register values on a combinational read port and the whole condition-field bank as a flat vector. It also receives the mode, two 3-bit selectors, a two-predicate flag, a vector-prefixed flag and the vector length. The caller pulses `valid` for one cycle. On the next clock edge both masks are registered and `done` is high for one cycle. The masks hold their value until the next strobe. The register file, the instruction decode and the element loop that uses the masks belong to other blocks.

Top module: `pred_mask_gen`

## Requirements
- R1: After reset both masks are all ones and `done` is low.
- R2: When `valid` is high at a rising clock edge, both masks take their new value at that edge and `done` is high for exactly the following cycle. When `valid` is low, the masks keep their value and `done` goes low.
- R3: When `vecMode` is 0 both masks are all ones, whatever the mode, selectors, registers, fields and vector length are.
- R4: In vector mode, a `predMode` of 0 (none) or 3 (reserved) gives all-ones masks. A `predMode` of 1 selects integer decoding and 2 selects condition decoding.
- R5: In integer mode the 3-bit selector picks the mask as follows: 0 is all ones, 1 is unary r3, 2 is r3, 3 is ~r3, 4 is r10, 5 is ~r10, 6 is r30 and 7 is ~r30. The vector length has no effect in this mode.
- R6: The unary selector (1) gives a one-hot mask whose single set bit is at the position given by bits [5:0] of r3. The higher bits of r3 are ignored.
- R7: In condition mode, selector bits [2:1] name the bit of each field and selector bit 0 set to 0 requires that bit to be 1, set to 1 requires it to be 0. So the selectors run LT, GE, GT, LE, EQ, NE, SO, NS for 0 to 7. Field f occupies `crBank[4f+3:4f]`, and its bit k is `crBank[4f+k]`. Mask bit i, for i below the vector length, is set when bit k of field CR_OFFSET+i (default offset 32) matches the required value.
- R8: In condition mode, mask bits at positions equal to or above the vector length are zero. A length of 0 gives an all-zero mask, and a length of 64 or more fills all 64 bits.
- R9: `dstMask` always comes from `dstSel`. `srcMask` equals `dstMask` unless `twoPred` is 1, in which case `srcMask` is decoded in the same mode from `srcSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | One-cycle strobe that loads new masks |
| vecMode | input | 1 | Instruction is vector-prefixed |
| predMode | input | 2 | 0 none, 1 integer, 2 condition, 3 reserved (treated as none) |
| dstSel | input | 3 | Destination predicate selector |
| srcSel | input | 3 | Source predicate selector |
| twoPred | input | 1 | Source mask uses its own selector |
| vecLen | input | 7 | Vector length |
| gpr3 | input | 64 | Value of register r3 |
| gpr10 | input | 64 | Value of register r10 |
| gpr30 | input | 64 | Value of register r30 |
| crBank | input | 512 | 128 condition fields, 4 bits each, field 0 in the lowest bits |
| srcMask | output | 64 | Registered source element mask |
| dstMask | output | 64 | Registered destination element mask |
| done | output | 1 | High for one cycle after each load |

## Verification
The bench aims at the edges of the condition-mode gather, with vector lengths of 0, 1, 5, 63, 64 and above 64. A design that gets the bound off by one would leave a stray bit set at position VL or would drop the last element. The unary selector is tested with upper bits set in r3, which catches a design that shifts by more than six bits and loses the single set bit. It is also tested at position 63. The single-predicate and two-predicate cases are mixed so that a source mask wrongly decoded from `srcSel` shows up as a mismatch. Scalar instructions and the reserved mode are given masks that would otherwise be non-trivial, and a `valid`-low cycle with changed inputs follows each load, so that a mask that is not forced to ones or not held shows up at once.

// File: rtl/pred_mask_pkg.sv
package pred_mask_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INT  = 2'd1,
    PM_CR   = 2'd2,
    PM_RSVD = 2'd3
  } predMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture new masks this edge
    logic forceOnes;  // scalar instruction or no predication
    logic useCr;      // condition-field decoding instead of integer
    logic splitSrc;   // source mask from its own selector
  } ctrlStrobe_t;
endpackage

// File: rtl/pred_mask_sel.sv
module pred_mask_sel
  import pred_mask_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NUM_FIELDS = 128,
  parameter int CR_OFFSET  = 32,
  parameter int VL_W       = 7
) (
  input  logic                    useCr,
  input  logic [2:0]              sel,
  input  logic [XLEN-1:0]         gpr3,
  input  logic [XLEN-1:0]         gpr10,
  input  logic [XLEN-1:0]         gpr30,
  input  logic [4*NUM_FIELDS-1:0] crBank,
  input  logic [VL_W-1:0]         vecLen,
  output logic [XLEN-1:0]         mask
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] intBits;
  logic [XLEN-1:0] crBits;
  logic [1:0]      bitIdx;
  logic            wantOne;

  assign bitIdx  = sel[2:1];
  assign wantOne = ~sel[0];

  always_comb begin
    unique case (sel)
      3'd0:    intBits = '1;
      3'd1:    intBits = {{(XLEN-1){1'b0}}, 1'b1} << gpr3[SH_W-1:0];
      3'd2:    intBits = gpr3;
      3'd3:    intBits = ~gpr3;
      3'd4:    intBits = gpr10;
      3'd5:    intBits = ~gpr10;
      3'd6:    intBits = gpr30;
      default: intBits = ~gpr30;
    endcase
  end

  for (genvar gi = 0; gi < XLEN; gi++) begin : g_gather
    localparam int FBASE = 4 * (CR_OFFSET + gi);
    logic [3:0] fieldBits;
    assign fieldBits  = crBank[FBASE +: 4];
    assign crBits[gi] = (VL_W'(gi) < vecLen) && (fieldBits[bitIdx] == wantOne);
  end

  assign mask = useCr ? crBits : intBits;
endmodule

// File: rtl/pred_mask_ctrl.sv
module pred_mask_ctrl
  import pred_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic        vecMode,
  input  logic [1:0]  predMode,
  input  logic        twoPred,
  output ctrlStrobe_t strobe,
  output logic        done
);
  predMode_e modeSel;
  assign modeSel = predMode_e'(predMode);

  always_comb begin
    strobe.load      = valid;
    strobe.forceOnes = !vecMode || (modeSel == PM_NONE) || (modeSel == PM_RSVD);
    strobe.useCr     = (modeSel == PM_CR);
    strobe.splitSrc  = twoPred;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= valid;
  end
endmodule

// File: rtl/pred_mask_dp.sv
module pred_mask_dp
  import pred_mask_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NUM_FIELDS = 128,
  parameter int CR_OFFSET  = 32,
  parameter int VL_W       = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [2:0]              dstSel,
  input  logic [2:0]              srcSel,
  input  logic [XLEN-1:0]         gpr3,
  input  logic [XLEN-1:0]         gpr10,
  input  logic [XLEN-1:0]         gpr30,
  input  logic [4*NUM_FIELDS-1:0] crBank,
  input  logic [VL_W-1:0]         vecLen,
  output logic [XLEN-1:0]         srcMask,
  output logic [XLEN-1:0]         dstMask
);
  logic [XLEN-1:0] dstDec, srcDec, dstNext, srcNext;

  pred_mask_sel #(.XLEN(XLEN), .NUM_FIELDS(NUM_FIELDS), .CR_OFFSET(CR_OFFSET), .VL_W(VL_W))
  u_dstSel (.useCr(strobe.useCr), .sel(dstSel), .gpr3(gpr3), .gpr10(gpr10), .gpr30(gpr30),
            .crBank(crBank), .vecLen(vecLen), .mask(dstDec));

  pred_mask_sel #(.XLEN(XLEN), .NUM_FIELDS(NUM_FIELDS), .CR_OFFSET(CR_OFFSET), .VL_W(VL_W))
  u_srcSel (.useCr(strobe.useCr), .sel(srcSel), .gpr3(gpr3), .gpr10(gpr10), .gpr30(gpr30),
            .crBank(crBank), .vecLen(vecLen), .mask(srcDec));

  assign dstNext = strobe.forceOnes ? '1 : dstDec;
  assign srcNext = strobe.forceOnes ? '1 : (strobe.splitSrc ? srcDec : dstDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcMask <= '1;
      dstMask <= '1;
    end else if (strobe.load) begin
      srcMask <= srcNext;
      dstMask <= dstNext;
    end
  end
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pred_mask_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NUM_FIELDS = 128,
  parameter int CR_OFFSET  = 32,
  parameter int VL_W       = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    valid,
  input  logic                    vecMode,
  input  logic [1:0]              predMode,
  input  logic [2:0]              dstSel,
  input  logic [2:0]              srcSel,
  input  logic                    twoPred,
  input  logic [VL_W-1:0]         vecLen,
  input  logic [XLEN-1:0]         gpr3,
  input  logic [XLEN-1:0]         gpr10,
  input  logic [XLEN-1:0]         gpr30,
  input  logic [4*NUM_FIELDS-1:0] crBank,
  output logic [XLEN-1:0]         srcMask,
  output logic [XLEN-1:0]         dstMask,
  output logic                    done
);
  localparam int CR_W = 4 * NUM_FIELDS;
  localparam logic [CR_W-1:0] WINDOW = {(4*XLEN){1'b1}} << (4*CR_OFFSET);

  ctrlStrobe_t strobe;
  logic        unusedCrBits;

  // fields outside the gather window are never read
  assign unusedCrBits = ^(crBank & ~WINDOW);

  pred_mask_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .vecMode(vecMode),
    .predMode(predMode), .twoPred(twoPred), .strobe(strobe), .done(done)
  );

  pred_mask_dp #(.XLEN(XLEN), .NUM_FIELDS(NUM_FIELDS), .CR_OFFSET(CR_OFFSET), .VL_W(VL_W))
  u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dstSel(dstSel), .srcSel(srcSel),
    .gpr3(gpr3), .gpr10(gpr10), .gpr30(gpr30), .crBank(crBank), .vecLen(vecLen),
    .srcMask(srcMask), .dstMask(dstMask)
  );
endmodule

// File: rtl/pred_mask_chk.sv
module pred_mask_chk #(
  parameter int XLEN = 64,
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            valid,
  input logic            vecMode,
  input logic [1:0]      predMode,
  input logic [2:0]      dstSel,
  input logic            twoPred,
  input logic [VL_W-1:0] vecLen,
  input logic [XLEN-1:0] srcMask,
  input logic [XLEN-1:0] dstMask,
  input logic            done
);
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> done);                                                   // R2
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> !done);                                                 // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(srcMask) && $stable(dstMask)));                // R2
  AST_SCALAR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !vecMode) |=> ((&srcMask) && (&dstMask)));               // R3
  AST_NOPRED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (predMode == 2'd0 || predMode == 2'd3)) |=> ((&srcMask) && (&dstMask))); // R4
  AST_UNARY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (valid && vecMode && predMode == 2'd1 && dstSel == 3'd1) |=> ($countones(dstMask) == 1)); // R6
  AST_CR_ABOVE_VL: assert property (@(posedge clk) disable iff (!rstN)
    (valid && vecMode && predMode == 2'd2 && vecLen < VL_W'(XLEN))
      |=> ((dstMask >> $past(vecLen)) == '0));                         // R8
  AST_SINGLE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !twoPred) |=> (srcMask == dstMask));                     // R9
endmodule

bind pred_mask_gen pred_mask_chk #(.XLEN(XLEN), .VL_W(VL_W)) u_chk (
  .clk(clk), .rstN(rstN), .valid(valid), .vecMode(vecMode), .predMode(predMode),
  .dstSel(dstSel), .twoPred(twoPred), .vecLen(vecLen), .srcMask(srcMask),
  .dstMask(dstMask), .done(done)
);

// File: tb/pred_mask_gen_tb.sv
module pred_mask_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFFS = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         valid = 1'b0, vecMode = 1'b0, twoPred = 1'b0;
  logic [1:0]   predMode = '0;
  logic [2:0]   dstSel = '0, srcSel = '0;
  logic [6:0]   vecLen = '0;
  logic [63:0]  gpr3 = '0, gpr10 = '0, gpr30 = '0;
  logic [511:0] crBank = '0;
  logic [63:0]  srcMask, dstMask;
  logic         done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_mask_gen u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .vecMode(vecMode), .predMode(predMode),
    .dstSel(dstSel), .srcSel(srcSel), .twoPred(twoPred), .vecLen(vecLen),
    .gpr3(gpr3), .gpr10(gpr10), .gpr30(gpr30), .crBank(crBank),
    .srcMask(srcMask), .dstMask(dstMask), .done(done)
  );

  function automatic logic [63:0] decodeSel(input logic [1:0] md, input logic [2:0] s);
    logic [63:0] m;
    m = '0;
    if (md == 2'd1) begin
      case (s)
        3'd0: m = '1;
        3'd1: begin m = '0; m[gpr3[5:0]] = 1'b1; end
        3'd2: m = gpr3;
        3'd3: m = ~gpr3;
        3'd4: m = gpr10;
        3'd5: m = ~gpr10;
        3'd6: m = gpr30;
        default: m = ~gpr30;
      endcase
    end else begin
      for (int i = 0; i < 64; i++)
        if (i < int'(vecLen))
          m[i] = (crBank[4*(OFFS+i) + int'(s[2:1])] == !s[0]);
    end
    return m;
  endfunction

  function automatic logic [63:0] expDst();
    if (!vecMode || predMode == 2'd0 || predMode == 2'd3) return '1;
    return decodeSel(predMode, dstSel);
  endfunction

  function automatic logic [63:0] expSrc();
    if (!vecMode || predMode == 2'd0 || predMode == 2'd3) return '1;
    return twoPred ? decodeSel(predMode, srcSel) : decodeSel(predMode, dstSel);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randomBank();
    for (int w = 0; w < 16; w++) crBank[32*w +: 32] = $urandom;
  endtask

  // load one set of inputs, check result, then check hold with junk inputs
  task automatic run(input string req);
    logic [63:0] eS, eD;
    @(negedge clk);
    valid = 1'b1;
    eS = expSrc();
    eD = expDst();
    @(posedge clk); #1;
    check64(req, dstMask, eD);
    check64({req, " src"}, srcMask, eS);
    check64("R2 done", {63'd0, done}, 64'd1);
    @(negedge clk);
    valid = 1'b0;
    gpr3 = {$urandom, $urandom};
    dstSel = dstSel + 3'd1;
    vecMode = ~vecMode;
    @(posedge clk); #1;
    check64("R2 hold", dstMask, eD);
    check64("R2 hold src", srcMask, eS);
    check64("R2 done low", {63'd0, done}, 64'd0);
  endtask

  task automatic setup(input logic vm, input logic [1:0] md, input logic [2:0] ds,
                       input logic [2:0] ss, input logic tp, input logic [6:0] vl);
    @(negedge clk);
    vecMode = vm; predMode = md; dstSel = ds; srcSel = ss; twoPred = tp; vecLen = vl;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check64("R1 dst reset", dstMask, '1);
    check64("R1 src reset", srcMask, '1);
    check64("R1 done reset", {63'd0, done}, 64'd0);
    @(negedge clk); rstN = 1'b1;

    gpr3 = 64'h0123_4567_89ab_cdef; gpr10 = 64'hf0f0_0000_ffff_1111; gpr30 = 64'h8000_0000_0000_0001;
    randomBank();

    setup(1'b0, 2'd1, 3'd2, 3'd4, 1'b1, 7'd10); run("R3 scalar int");
    setup(1'b0, 2'd2, 3'd0, 3'd1, 1'b0, 7'd10); run("R3 scalar cr");
    setup(1'b1, 2'd0, 3'd3, 3'd3, 1'b0, 7'd10); run("R4 mode none");
    setup(1'b1, 2'd3, 3'd2, 3'd5, 1'b1, 7'd10); run("R4 mode reserved");
    for (int s = 0; s < 8; s++) begin
      setup(1'b1, 2'd1, 3'(s), 3'(7 - s), 1'b1, 7'd3); run("R5 int selector");
    end
    setup(1'b1, 2'd1, 3'd1, 3'd0, 1'b0, 7'd0);
    gpr3 = 64'hffff_ffff_ffff_ffc0; run("R6 unary pos0 upper bits");
    setup(1'b1, 2'd1, 3'd1, 3'd0, 1'b0, 7'd0);
    gpr3 = 64'h0000_0000_0000_007f; run("R6 unary pos63");
    for (int s = 0; s < 8; s++) begin
      setup(1'b1, 2'd2, 3'(s), 3'(s ^ 1), 1'b1, 7'd64); run("R7 cr selector");
    end
    setup(1'b1, 2'd2, 3'd0, 3'd1, 1'b0, 7'd0);   run("R8 vl zero");
    setup(1'b1, 2'd2, 3'd1, 3'd1, 1'b0, 7'd1);   run("R8 vl one");
    setup(1'b1, 2'd2, 3'd4, 3'd5, 1'b1, 7'd5);   run("R8 vl five");
    setup(1'b1, 2'd2, 3'd7, 3'd6, 1'b1, 7'd63);  run("R8 vl 63");
    setup(1'b1, 2'd2, 3'd2, 3'd3, 1'b0, 7'd100); run("R8 vl above 64");
    setup(1'b1, 2'd1, 3'd4, 3'd6, 1'b0, 7'd9);   run("R9 single pred int");
    setup(1'b1, 2'd2, 3'd3, 3'd0, 1'b0, 7'd40);  run("R9 single pred cr");

    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      gpr3 = {$urandom, $urandom}; gpr10 = {$urandom, $urandom}; gpr30 = {$urandom, $urandom};
      randomBank();
      setup(1'($urandom), 2'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), 7'($urandom % 80));
      run("R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule